// File: doc/BRIEF.md
# ADC Output Test Word Generator

This block sits in front of a converter's parallel output bus and, when a test pattern is selected, replaces the live sample words with a known 16-bit sequence. Downstream capture logic can then check the data path without an analog input. It produces one word per sample clock, with a valid flag and a flag that marks test words. When no pattern is selected, live samples and their valid flag pass through unchanged, one register stage late.

The pattern is chosen with a 4-bit select code. A 2-bit user mode sets how two programmable user words are played: repeat the first, alternate both, play the first once, or play both once. The user words are loaded one byte lane at a time. A long (23-bit) and a short (9-bit) pseudo-random generator run freely, and each can be reseeded on its own. Writing the select restarts the chosen sequence. Writing the user mode restarts the user-word sequence.

The user-word player is a three-state machine:
- FIRST presents user word 1.
- SECOND presents user word 2.
- DONE presents zero.

From FIRST the machine stays in FIRST under repeat, moves to SECOND under alternate and alternate-once, and moves to DONE under once. From SECOND it goes back to FIRST under alternate and moves to DONE under alternate-once. DONE holds. A write to the select or to the mode returns the machine to FIRST. The machine advances only while the user-word code is selected.

Top module: `adc_test_word_gen`

## Requirements
- R1: After reset, `out_data`, `out_valid` and `out_test` are 0. The select is 0 (off), both user words are zero, both generators hold all ones, and the user-word machine is in FIRST.
- R2: While the select is 0, each clock registers `live_data` and `live_valid` onto `out_data` and `out_valid`, and drives `out_test` to 0.
- R3: While the select is non-zero, `out_test` and `out_valid` are 1 and the live inputs are ignored. A select write is loaded at clock k. The first word of the new sequence (word index 0) is registered at clock k+1. Word index n is registered n clocks later.
- R4: Code 1 gives 0x8000, code 2 gives 0xFFFF and code 3 gives 0x0000 on every word. The unused codes 13, 14 and 15 also give 0x0000 with `out_test` high.
- R5: Even word indices give the first value and odd indices the second. Code 4 alternates 0xAAAA and 0x5555. Code 7 alternates 0xFFFF and 0x0000. Code 9 alternates 0xFF00 and 0x00FF.
- R6: Code 10 gives 0xFFFF at word index 0 and 0x0000 at every later index.
- R7: Code 11 gives a single high bit at position (n mod 16) for word index n, starting at 0x0001.
- R8: Code 12 gives the word index itself, n mod 65536, so bit i toggles every 2^i words.
- R9: Code 5 plays the long generator, x^23+x^18+1. Each clock the register shifts left, and bit 22 XOR bit 17 enters bit 0. The word is register bits 22:7. The generator reseeds to all ones on a select write, so word index 0 is 0xFFFF.
- R10: Code 6 plays the short generator, x^9+x^5+1. Each clock the register shifts left, and bit 8 XOR bit 4 enters bit 0. The word is the 9 register bits followed by register bits 8:2. It reseeds to all ones on a select write.
- R11: Both generators step every clock. `pn_long_rst` reseeds only the long generator and `pn_short_rst` reseeds only the short one. The reseeded value shows on the next registered word.
- R12: With code 8, the user mode picks the order: 0 repeats word 1, 1 alternates word 1 and word 2, 2 plays word 1 once, 3 plays word 1 then word 2 once.
- R13: In the once modes, the output is 0x0000 after the last user word until the select or the user mode is written. A mode write restarts the sequence at word 1 on the next registered word.
- R14: A write with `pat_wr` loads `pat_byte` into one byte of one user word. `pat_sel`=0 picks word 1 and 1 picks word 2. `pat_lane`=0 picks bits 7:0 and 1 picks bits 15:8. The new value shows on the next registered word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Loads `sel_in` into the pattern select and restarts the sequence |
| sel_in | input | 4 | Pattern select code (0 = off) |
| mode_wr | input | 1 | Loads `mode_in` into the user mode and restarts the user sequence |
| mode_in | input | 2 | User-word play mode |
| pat_wr | input | 1 | User-word byte write strobe |
| pat_sel | input | 1 | User word chosen by a byte write (0 = word 1, 1 = word 2) |
| pat_lane | input | 1 | Byte lane chosen by a byte write (0 = low, 1 = high) |
| pat_byte | input | 8 | Byte written into the chosen user word |
| pn_long_rst | input | 1 | Reseeds the 23-bit generator |
| pn_short_rst | input | 1 | Reseeds the 9-bit generator |
| live_data | input | 16 | Converted sample word |
| live_valid | input | 1 | Valid flag of the converted sample |
| out_data | output | 16 | Output word: test word or delayed live word |
| out_valid | output | 1 | Output valid flag |
| out_test | output | 1 | High when `out_data` carries a test word |

## Verification
The assertions assume that the select input carries one of the sixteen 4-bit codes and that write and reseed strobes are sampled cleanly at the clock. The single-high-bit check also assumes that every code-11 word comes from a select that was already 11 in the previous cycle. The stimulus changes every input at the falling edge only. It visits every select code, including the three unused ones, and pulses reseeds and mode writes in the middle of running sequences. Live data is random throughout, so any leak of live data into test words would show up.

// File: rtl/atpg_pkg.sv
package atpg_pkg;

    // pattern select codes; the numbering is visible at the port
    localparam logic [3:0] SEL_OFF      = 4'd0;
    localparam logic [3:0] SEL_MID      = 4'd1;
    localparam logic [3:0] SEL_POS_FS   = 4'd2;
    localparam logic [3:0] SEL_NEG_FS   = 4'd3;
    localparam logic [3:0] SEL_CHECKER  = 4'd4;
    localparam logic [3:0] SEL_PN_LONG  = 4'd5;
    localparam logic [3:0] SEL_PN_SHORT = 4'd6;
    localparam logic [3:0] SEL_WORD_TOG = 4'd7;
    localparam logic [3:0] SEL_USER     = 4'd8;
    localparam logic [3:0] SEL_BYTE_TOG = 4'd9;
    localparam logic [3:0] SEL_SYNC     = 4'd10;
    localparam logic [3:0] SEL_WALK     = 4'd11;
    localparam logic [3:0] SEL_MIXED    = 4'd12;

    // user-word play modes
    localparam logic [1:0] UM_REPEAT   = 2'd0;
    localparam logic [1:0] UM_ALT      = 2'd1;
    localparam logic [1:0] UM_ONCE     = 2'd2;
    localparam logic [1:0] UM_ALT_ONCE = 2'd3;

    typedef enum logic [1:0] {
        US_FIRST  = 2'd0,
        US_SECOND = 2'd1,
        US_DONE   = 2'd2
    } useq_state_e;

endpackage

// File: rtl/atpg_pn_gen.sv
module atpg_pn_gen #(
    parameter int LEN    = 23,
    parameter int TAP    = 18,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reseed,
    output logic [WORD_W-1:0] word
);

    logic [LEN-1:0] r_q;
    logic           fb;

    assign fb = r_q[LEN-1] ^ r_q[TAP-1];

    always_ff @(posedge clk) begin
        if (!rst_n || reseed) begin
            r_q <= '1;
        end else begin
            r_q <= {r_q[LEN-2:0], fb};
        end
    end

    generate
        if (LEN >= WORD_W) begin : g_top_slice
            assign word = r_q[LEN-1 -: WORD_W];
        end else begin : g_wrap_fill
            localparam int FILL = WORD_W - LEN;
            assign word = {r_q, r_q[LEN-1 -: FILL]};
        end
    endgenerate

endmodule

// File: rtl/atpg_user_seq.sv
module atpg_user_seq
    import atpg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        advance,
    input  logic [1:0]  mode,
    output useq_state_e state
);

    useq_state_e state_q;
    useq_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= US_FIRST;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = US_FIRST;
        end else if (advance) begin
            unique case (state_q)
                US_FIRST: begin
                    if (mode == UM_ONCE)        state_d = US_DONE;
                    else if (mode == UM_REPEAT) state_d = US_FIRST;
                    else                        state_d = US_SECOND;
                end
                US_SECOND: begin
                    if (mode == UM_ALT_ONCE) state_d = US_DONE;
                    else                     state_d = US_FIRST;
                end
                US_DONE:  state_d = US_DONE;
                default:  state_d = US_FIRST;
            endcase
        end
    end

    // outputs
    assign state = state_q;

endmodule

// File: rtl/atpg_word_sel.sv
module atpg_word_sel
    import atpg_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic [3:0]        sel,
    input  logic [WORD_W-1:0] step,
    input  logic [WORD_W-1:0] pn_long_word,
    input  logic [WORD_W-1:0] pn_short_word,
    input  logic [WORD_W-1:0] user_word,
    output logic [WORD_W-1:0] word
);

    localparam int HALF  = WORD_W / 2;
    localparam int IDX_W = $clog2(WORD_W);

    localparam logic [WORD_W-1:0] W_MID  = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] W_CHKA = {HALF{2'b10}};
    localparam logic [WORD_W-1:0] W_CHKB = {HALF{2'b01}};
    localparam logic [WORD_W-1:0] W_BYTA = {{HALF{1'b1}}, {HALF{1'b0}}};
    localparam logic [WORD_W-1:0] W_BYTB = {{HALF{1'b0}}, {HALF{1'b1}}};
    localparam logic [WORD_W-1:0] W_ONE  = {{(WORD_W-1){1'b0}}, 1'b1};

    logic odd;
    assign odd = step[0];

    always_comb begin
        unique case (sel)
            SEL_MID:      word = W_MID;
            SEL_POS_FS:   word = '1;
            SEL_NEG_FS:   word = '0;
            SEL_CHECKER:  word = odd ? W_CHKB : W_CHKA;
            SEL_PN_LONG:  word = pn_long_word;
            SEL_PN_SHORT: word = pn_short_word;
            SEL_WORD_TOG: word = odd ? '0 : '1;
            SEL_USER:     word = user_word;
            SEL_BYTE_TOG: word = odd ? W_BYTB : W_BYTA;
            SEL_SYNC:     word = (step == '0) ? '1 : '0;
            SEL_WALK:     word = W_ONE << step[IDX_W-1:0];
            SEL_MIXED:    word = step;
            default:      word = '0;
        endcase
    end

endmodule

// File: rtl/adc_test_word_gen.sv
module adc_test_word_gen
    import atpg_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int PN_LONG_LEN = 23,
    parameter int PN_LONG_TAP = 18,
    parameter int PN_SHRT_LEN = 9,
    parameter int PN_SHRT_TAP = 5,
    parameter int LANE_W      = $clog2(WORD_W / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [3:0]        sel_in,
    input  logic              mode_wr,
    input  logic [1:0]        mode_in,
    input  logic              pat_wr,
    input  logic              pat_sel,
    input  logic [LANE_W-1:0] pat_lane,
    input  logic [7:0]        pat_byte,
    input  logic              pn_long_rst,
    input  logic              pn_short_rst,
    input  logic [WORD_W-1:0] live_data,
    input  logic              live_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_test
);

    localparam int LANES = WORD_W / 8;

    logic [3:0]        sel_q;
    logic [1:0]        mode_q;
    logic [WORD_W-1:0] step_q;
    logic [WORD_W-1:0] pat1_q;
    logic [WORD_W-1:0] pat2_q;
    logic [WORD_W-1:0] pn_long_word;
    logic [WORD_W-1:0] pn_short_word;
    logic [WORD_W-1:0] user_word;
    logic [WORD_W-1:0] test_word;
    logic              test_on;
    useq_state_e       useq_state;

    assign test_on = (sel_q != SEL_OFF);

    // configuration and word index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= SEL_OFF;
            mode_q <= UM_REPEAT;
            step_q <= '0;
        end else begin
            if (sel_wr)  sel_q  <= sel_in;
            if (mode_wr) mode_q <= mode_in;
            step_q <= sel_wr ? '0 : step_q + 1'b1;
        end
    end

    // user word byte lanes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat1_q <= '0;
            pat2_q <= '0;
        end else if (pat_wr) begin
            for (int l = 0; l < LANES; l++) begin
                if (pat_lane == LANE_W'(l)) begin
                    if (pat_sel) pat2_q[l*8 +: 8] <= pat_byte;
                    else         pat1_q[l*8 +: 8] <= pat_byte;
                end
            end
        end
    end

    atpg_pn_gen #(
        .LEN    (PN_LONG_LEN),
        .TAP    (PN_LONG_TAP),
        .WORD_W (WORD_W)
    ) u_pn_long (
        .clk    (clk),
        .rst_n  (rst_n),
        .reseed (sel_wr | pn_long_rst),
        .word   (pn_long_word)
    );

    atpg_pn_gen #(
        .LEN    (PN_SHRT_LEN),
        .TAP    (PN_SHRT_TAP),
        .WORD_W (WORD_W)
    ) u_pn_short (
        .clk    (clk),
        .rst_n  (rst_n),
        .reseed (sel_wr | pn_short_rst),
        .word   (pn_short_word)
    );

    atpg_user_seq u_useq (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (sel_wr | mode_wr),
        .advance (sel_q == SEL_USER),
        .mode    (mode_q),
        .state   (useq_state)
    );

    always_comb begin
        unique case (useq_state)
            US_FIRST:  user_word = pat1_q;
            US_SECOND: user_word = pat2_q;
            default:   user_word = '0;
        endcase
    end

    atpg_word_sel #(
        .WORD_W (WORD_W)
    ) u_word_sel (
        .sel           (sel_q),
        .step          (step_q),
        .pn_long_word  (pn_long_word),
        .pn_short_word (pn_short_word),
        .user_word     (user_word),
        .word          (test_word)
    );

    // output stage: test word or live sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            out_test  <= 1'b0;
        end else begin
            out_data  <= test_on ? test_word : live_data;
            out_valid <= test_on | live_valid;
            out_test  <= test_on;
        end
    end

endmodule

// File: rtl/adc_test_word_gen_chk.sv
module adc_test_word_gen_chk
    import atpg_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_wr,
    input logic [3:0]        sel_in,
    input logic              mode_wr,
    input logic              pn_long_rst,
    input logic              pn_short_rst,
    input logic [WORD_W-1:0] live_data,
    input logic              live_valid,
    input logic [WORD_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_test,
    input logic [3:0]        sel_q,
    input logic [1:0]        mode_q,
    input useq_state_e       useq_state,
    input logic [WORD_W-1:0] pn_long_word,
    input logic [WORD_W-1:0] pn_short_word
);

    assert_live_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == SEL_OFF) |=> (out_data == $past(live_data) &&
                                out_valid == $past(live_valid) && !out_test));

    assert_sel_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> (sel_q == $past(sel_in)));

    assert_test_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != SEL_OFF) |=> (out_test && out_valid));

    assert_midscale_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_q) == SEL_MID) |-> (out_data == {1'b1, {(WORD_W-1){1'b0}}}));

    assert_walk_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_q) == SEL_WALK) |-> ($countones(out_data) == 1));

    assert_long_seed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pn_long_rst || sel_wr) |=> (pn_long_word == '1));

    assert_short_seed_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pn_short_rst || sel_wr) |=> (pn_short_word == '1));

    assert_second_alt_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (useq_state == US_SECOND) |-> mode_q[0]);

    assert_once_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (useq_state == US_DONE && !sel_wr && !mode_wr) |=> (useq_state == US_DONE));

endmodule

bind adc_test_word_gen adc_test_word_gen_chk #(.WORD_W(WORD_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_wr        (sel_wr),
    .sel_in        (sel_in),
    .mode_wr       (mode_wr),
    .pn_long_rst   (pn_long_rst),
    .pn_short_rst  (pn_short_rst),
    .live_data     (live_data),
    .live_valid    (live_valid),
    .out_data      (out_data),
    .out_valid     (out_valid),
    .out_test      (out_test),
    .sel_q         (sel_q),
    .mode_q        (mode_q),
    .useq_state    (useq_state),
    .pn_long_word  (pn_long_word),
    .pn_short_word (pn_short_word)
);

// File: tb/adc_test_word_gen_tb.sv
`timescale 1ns/1ps
module adc_test_word_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr = 1'b0;
    logic [3:0]  sel_in = '0;
    logic        mode_wr = 1'b0;
    logic [1:0]  mode_in = '0;
    logic        pat_wr = 1'b0;
    logic        pat_sel = 1'b0;
    logic [0:0]  pat_lane = '0;
    logic [7:0]  pat_byte = '0;
    logic        pn_long_rst = 1'b0;
    logic        pn_short_rst = 1'b0;
    logic [15:0] live_data = '0;
    logic        live_valid = 1'b0;
    logic [15:0] out_data;
    logic        out_valid;
    logic        out_test;

    always #2 clk = ~clk;

    adc_test_word_gen u_dut (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_in(sel_in),
        .mode_wr(mode_wr), .mode_in(mode_in), .pat_wr(pat_wr),
        .pat_sel(pat_sel), .pat_lane(pat_lane), .pat_byte(pat_byte),
        .pn_long_rst(pn_long_rst), .pn_short_rst(pn_short_rst),
        .live_data(live_data), .live_valid(live_valid),
        .out_data(out_data), .out_valid(out_valid), .out_test(out_test)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // behavioural reference state
    int          m_sel = 0, m_mode = 0, m_step = 0, m_us = 0;
    int unsigned m_p23 = 32'h7FFFFF, m_p9 = 32'h1FF;
    int          m_pat1 = 0, m_pat2 = 0;
    logic [15:0] e_data = '0;
    logic        e_valid = 1'b0, e_test = 1'b0;

    function automatic string tag_for(int s);
        case (s)
            0:        return "R2";
            4, 7, 9:  return "R5";
            5:        return "R9";
            6:        return "R10";
            8:        return "R12";
            10:       return "R6";
            11:       return "R7";
            12:       return "R8";
            default:  return "R4";
        endcase
    endfunction

    function automatic int model_word();
        int odd = m_step % 2;
        case (m_sel)
            1:  return 'h8000;
            2:  return 'hFFFF;
            4:  return odd ? 'h5555 : 'hAAAA;
            5:  return (m_p23 >> 7) & 'hFFFF;
            6:  return ((m_p9 << 7) | (m_p9 >> 2)) & 'hFFFF;
            7:  return odd ? 'h0000 : 'hFFFF;
            8:  return (m_us == 0) ? m_pat1 : (m_us == 1) ? m_pat2 : 0;
            9:  return odd ? 'h00FF : 'hFF00;
            10: return (m_step == 0) ? 'hFFFF : 0;
            11: return 1 << (m_step % 16);
            12: return m_step;
            default: return 0;
        endcase
    endfunction

    task automatic compare(string req);
        n_checks++;
        if (out_data !== e_data || out_valid !== e_valid || out_test !== e_test) begin
            n_fail++;
            $display("FAIL %s sel=%0d: actual data=%h valid=%b test=%b expected data=%h valid=%b test=%b",
                     req, m_sel, out_data, out_valid, out_test, e_data, e_valid, e_test);
        end
    endtask

    // one clock: fresh live input, model step at the edge, compare at the falling edge
    task automatic tick(string tag = "");
        string req;
        int    nus;
        live_data  = 16'($urandom_range(0, 65535));
        live_valid = 1'($urandom_range(0, 1));
        req = (tag == "") ? tag_for(m_sel) : tag;
        @(posedge clk);
        if (m_sel == 0) begin
            e_data = live_data; e_valid = live_valid; e_test = 1'b0;
        end else begin
            e_data = 16'(model_word()); e_valid = 1'b1; e_test = 1'b1;
        end
        nus = m_us;
        if (sel_wr || mode_wr) nus = 0;
        else if (m_sel == 8) begin
            case (m_us)
                0: nus = (m_mode == 0) ? 0 : (m_mode == 2) ? 2 : 1;
                1: nus = (m_mode == 3) ? 2 : 0;
                default: nus = 2;
            endcase
        end
        m_us = nus;
        if (sel_wr || pn_long_rst) m_p23 = 32'h7FFFFF;
        else m_p23 = ((m_p23 << 1) | (((m_p23 >> 22) ^ (m_p23 >> 17)) & 1)) & 32'h7FFFFF;
        if (sel_wr || pn_short_rst) m_p9 = 32'h1FF;
        else m_p9 = ((m_p9 << 1) | (((m_p9 >> 8) ^ (m_p9 >> 4)) & 1)) & 32'h1FF;
        m_step = sel_wr ? 0 : (m_step + 1) % 65536;
        if (pat_wr) begin
            if (pat_sel) m_pat2 = pat_lane ? ((m_pat2 & 'hFF) | (pat_byte << 8)) : ((m_pat2 & 'hFF00) | pat_byte);
            else         m_pat1 = pat_lane ? ((m_pat1 & 'hFF) | (pat_byte << 8)) : ((m_pat1 & 'hFF00) | pat_byte);
        end
        if (sel_wr)  m_sel  = sel_in;
        if (mode_wr) m_mode = mode_in;
        @(negedge clk);
        compare(req);
    endtask

    task automatic run(int n, string tag = "");
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic write_sel(int v, string tag = "R3");
        sel_in = 4'(v); sel_wr = 1'b1; tick(tag); sel_wr = 1'b0;
    endtask

    task automatic write_mode(int v, string tag = "R13");
        mode_in = 2'(v); mode_wr = 1'b1; tick(tag); mode_wr = 1'b0;
    endtask

    task automatic write_byte(int which, int lane, int b);
        pat_wr = 1'b1; pat_sel = 1'(which); pat_lane = 1'(lane); pat_byte = 8'(b);
        tick("R14");
        pat_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        e_data = '0; e_valid = 1'b0; e_test = 1'b0;
        compare("R1");
        rst_n = 1'b1;

        // R1: user words read zero straight after reset
        write_sel(8, "R1");
        run(3, "R1");
        write_sel(0, "R1");

        // R2: live pass-through
        run(12, "R2");

        // every code, each restarted by its select write (R3..R10)
        for (int s = 1; s < 16; s++) begin
            write_sel(s);
            run(s == 11 ? 40 : 20);
        end
        write_sel(0);
        run(4, "R2");

        // R8: mixed pattern across many words
        write_sel(12);
        run(300, "R8");

        // R11: independent reseeds
        write_sel(5);
        run(15, "R11");
        pn_long_rst = 1'b1; tick("R11"); pn_long_rst = 1'b0;
        run(10, "R11");
        pn_short_rst = 1'b1; tick("R11"); pn_short_rst = 1'b0;
        run(6, "R11");
        write_sel(6);
        run(12, "R11");
        pn_long_rst = 1'b1; tick("R11"); pn_long_rst = 1'b0;
        run(6, "R11");
        pn_short_rst = 1'b1; tick("R11"); pn_short_rst = 1'b0;
        run(12, "R10");

        // R14: byte loading of both words
        write_byte(0, 0, 'h34);
        write_byte(0, 1, 'h12);
        write_byte(1, 0, 'hCD);
        write_byte(1, 1, 'hAB);

        // R12/R13: user modes
        write_sel(8);
        run(5, "R12");
        write_byte(0, 1, 'h9E);
        run(3, "R14");
        write_mode(1, "R12");
        run(7, "R12");
        write_mode(2, "R13");
        run(6, "R13");
        write_mode(3, "R13");
        run(7, "R13");
        write_mode(3, "R13");
        run(4, "R13");
        write_sel(8, "R13");
        run(5, "R13");
        write_mode(1, "R12");
        run(3, "R12");
        write_mode(0, "R12");
        run(4, "R12");

        write_sel(0);
        run(8, "R2");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule